// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Slave

This block is the target side of an 8-bit parallel host bus in which the low address byte and the data byte travel on the same lines. The host first places the low address on the shared lines and pulses an address-latch strobe. The slave captures that byte when the strobe falls and keeps it. The upper address arrives on dedicated pins: a 3-bit field for bits 10..8 and one separate pin for bit 11. Together they form a 12-bit word address into a 4096 x 8 register array held inside the block.

Chip select is built inside the block from eight spare address inputs, and it is active only while all eight are low. Reads and writes use active-low strobes. Each strobe passes through a two-stage synchronizer into the internal clock domain. The slave never stretches a cycle, so every host strobe has to last at least three internal clock periods. The shared bus is split into an input byte, an output byte and an output-enable, so the pad ring can build the tristate driver.

Top module: `muxbus_slave`

## Requirements
- R1: While reset is asserted and directly after it, `bus_oe` is 0 and `bus_out` is 0.
- R2: The low address byte is taken from `bus_in` when the synchronized `ale` falls.
- R3: The word address is {`adr_top`, `adr_hi`[2:0], latched low byte}. `adr_hi`[0] is address bit 8 and `adr_top` is address bit 11.
- R4: Chip select is active only when every bit of `sel_n`[7:0] is 0. Otherwise no read drives the bus.
- R5: A write stores the value of `bus_in` at the current address when the synchronized `wr_n` rises while chip select is active.
- R6: While chip select is active and `rd_n` is low (with `wr_n` high), `bus_oe` is 1 no later than the third clock edge after `rd_n` falls, and `bus_out` shows the stored byte at the current address.
- R7: When `bus_oe` is 0, `bus_out` is 0. `bus_oe` returns to 0 within three clock edges after `rd_n` rises.
- R8: The latched low byte keeps its value until the next `ale` falling edge, so several strobes may reuse one address.
- R9: If `rd_n` is low at any time while `wr_n` is low, that write stores nothing, and the bus is not driven during the overlap.
- R10: A write strobe completed while chip select is inactive changes no stored byte.
- R11: Strobes of three clock periods low and three or more high are accepted, because all strobe inputs pass through two-flop synchronizers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Shared lines as seen by the slave (low address or write data) |
| bus_out | output | 8 | Read data toward the shared lines |
| bus_oe | output | 1 | Output enable of the shared-line driver |
| adr_hi | input | 3 | Address bits 10..8, bit 8 on position 0 |
| adr_top | input | 1 | Address bit 11 |
| sel_n | input | 8 | Chip-select inputs, active when all are 0 |
| ale | input | 1 | Address-latch strobe, low byte taken on its fall |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |

## Verification
The read and the write strobe can be active in the same synchronized cycle. This is the collision the block must settle without corrupting storage. The bench provokes it in two ways: it lowers both strobes and raises them together, and it lowers both and raises the write strobe while the read strobe is still low. Each time it checks that the bus stays undriven during the overlap. It then reads the target address back and expects the byte it held before. The other pairing that can land in one cycle is a latch-strobe fall and a strobe edge. The bench sweeps every one of the 4096 addresses with distinct arithmetic data, and each low-byte capture is confirmed by the later readback.

// File: rtl/mux_pkg.sv
package mux_pkg;
  // Events produced by the strobe unit, one clock wide except re
  typedef struct packed {
    logic ale_fall;   // low address capture
    logic we;         // commit write this cycle
    logic re;         // read level qualified by select and no write
  } strobe_ev_t;
endpackage

// File: rtl/mux_sync.sv
module mux_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/mux_strobe.sv
module mux_strobe
  import mux_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ale_s,
  input  logic       wr_s,
  input  logic       rd_s,
  input  logic       cs_ok,
  output strobe_ev_t ev,
  output logic       cflt
);
  logic ale_p_q, wr_p_q, cflt_q;
  logic cflt_d;
  logic both_low, wr_rise;

  always_comb begin
    both_low = ~wr_s & ~rd_s;
    wr_rise  = ~wr_p_q & wr_s;
    cflt_d   = cflt_q;
    if (both_low)  cflt_d = 1'b1;
    else if (wr_s) cflt_d = 1'b0;
    ev.ale_fall = ale_p_q & ~ale_s;
    ev.we       = wr_rise & cs_ok & rd_s & ~cflt_q;
    ev.re       = ~rd_s & wr_s & cs_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_p_q <= 1'b0;
      wr_p_q  <= 1'b1;
      cflt_q  <= 1'b0;
    end else begin
      ale_p_q <= ale_s;
      wr_p_q  <= wr_s;
      cflt_q  <= cflt_d;
    end
  end

  assign cflt = cflt_q;
endmodule

// File: rtl/mux_addr.sv
module mux_addr #(
  parameter int DW  = 8,
  parameter int HIW = 3,
  localparam int AW = DW + HIW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic [DW-1:0]  lo_in,
  input  logic [HIW-1:0] hi_in,
  input  logic           top_in,
  output logic [DW-1:0]  lo_q,
  output logic [AW-1:0]  addr
);
  logic [DW-1:0] lo_d;

  always_comb begin
    lo_d = lo_q;
    if (cap_en) lo_d = lo_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_d;
  end

  assign addr = {top_in, hi_in, lo_q};
endmodule

// File: rtl/mux_regfile.sv
module mux_regfile #(
  parameter int AW = 12,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
  import mux_pkg::*;
#(
  parameter int DW  = 8,
  parameter int HIW = 3,
  parameter int CSW = 8,
  localparam int AW = DW + HIW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [DW-1:0]  bus_in,
  output logic [DW-1:0]  bus_out,
  output logic           bus_oe,
  input  logic [HIW-1:0] adr_hi,
  input  logic           adr_top,
  input  logic [CSW-1:0] sel_n,
  input  logic           ale,
  input  logic           wr_n,
  input  logic           rd_n
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  // strobe synchronizers, order {wr, rd, ale}
  logic [2:0] sy;
  mux_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d({wr_n, rd_n, ale}), .q(sy)
  );

  logic cs_ok;
  assign cs_ok = (sel_n == '0);

  strobe_ev_t ev;
  logic       cflt;
  mux_strobe u_strobe (
    .clk(clk), .rst_n(rst_i_n), .ale_s(sy[0]), .wr_s(sy[2]), .rd_s(sy[1]),
    .cs_ok(cs_ok), .ev(ev), .cflt(cflt)
  );

  logic ale_fall_w, we_w, re_w;
  assign ale_fall_w = ev.ale_fall;
  assign we_w       = ev.we;
  assign re_w       = ev.re;

  logic [DW-1:0] addr_lo;
  logic [AW-1:0] addr;
  mux_addr #(.DW(DW), .HIW(HIW)) u_addr (
    .clk(clk), .rst_n(rst_i_n), .cap_en(ale_fall_w), .lo_in(bus_in),
    .hi_in(adr_hi), .top_in(adr_top), .lo_q(addr_lo), .addr(addr)
  );

  logic [DW-1:0] rdata;
  mux_regfile #(.AW(AW), .DW(DW)) u_mem (
    .clk(clk), .we(we_w), .addr(addr), .wdata(bus_in), .rdata(rdata)
  );

  // output stage
  logic          oe_q, oe_d;
  logic [DW-1:0] dout_q, dout_d;
  always_comb begin
    oe_d   = re_w;
    dout_d = re_w ? rdata : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else begin
      oe_q   <= oe_d;
      dout_q <= dout_d;
    end
  end

  assign bus_oe  = oe_q;
  assign bus_out = dout_q;
endmodule

// File: rtl/mux_chk.sv
module mux_chk #(
  parameter int DW  = 8,
  parameter int CSW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_oe,
  input logic [DW-1:0]  bus_out,
  input logic [CSW-1:0] sel_n,
  input logic           ale_fall,
  input logic           we,
  input logic           rd_s,
  input logic           wr_s,
  input logic [DW-1:0]  lo_q
);
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(sel_n) == '0); // R4
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> bus_out == '0); // R7
  AST_LOW_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_fall |=> $stable(lo_q)); // R8
  AST_WRITE_NOT_READING: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> rd_s); // R9
  AST_DRIVE_NOT_WRITING: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(wr_s)); // R9
  AST_WRITE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> sel_n == '0); // R10
endmodule

bind muxbus_slave mux_chk #(.DW(DW), .CSW(CSW)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .bus_oe(bus_oe), .bus_out(bus_out),
  .sel_n(sel_n), .ale_fall(ale_fall_w), .we(we_w), .rd_s(sy[1]),
  .wr_s(sy[2]), .lo_q(addr_lo)
);

// File: tb/sim_muxbus_slave.sv
module sim_muxbus_slave;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_in;
  logic [7:0] bus_out;
  logic       bus_oe;
  logic [2:0] adr_hi;
  logic       adr_top;
  logic [7:0] sel_n;
  logic       ale, wr_n, rd_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  muxbus_slave u0 (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out),
    .bus_oe(bus_oe), .adr_hi(adr_hi), .adr_top(adr_top), .sel_n(sel_n),
    .ale(ale), .wr_n(wr_n), .rd_n(rd_n)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + (a >> 8) * 11 + 5) & 255);
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_addr(int a);
    adr_hi  = 3'(a >> 8);
    adr_top = 1'(a >> 11);
    bus_in  = 8'(a);
    ale = 1'b1; tick(3);
    ale = 1'b0; tick(4);
  endtask

  task automatic do_wr(logic [7:0] d);
    bus_in = d;
    wr_n = 1'b0; tick(3);
    wr_n = 1'b1; tick(4);
  endtask

  task automatic do_rd(logic [7:0] exp, string req);
    rd_n = 1'b0; tick(3);
    check(bus_oe === 1'b1 && bus_out === exp, req, {bus_oe, bus_out}, {1'b1, exp});
    rd_n = 1'b1; tick(3);
  endtask

  initial begin
    rst_n = 1'b0; bus_in = '0; adr_hi = '0; adr_top = 1'b0; sel_n = '0;
    ale = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
    tick(3);
    check(bus_oe === 1'b0 && bus_out === 8'h00, "R1 in reset", {bus_oe, bus_out}, 0);
    rst_n = 1'b1; tick(4);
    check(bus_oe === 1'b0 && bus_out === 8'h00, "R1 after reset", {bus_oe, bus_out}, 0);

    // R2 R3 R5 R11: fill every address with 3-cycle strobes
    for (int a = 0; a < 4096; a++) begin
      set_addr(a);
      do_wr(pat(a));
    end
    // R6 R3 R2: read every address back
    for (int a = 0; a < 4096; a++) begin
      set_addr(a);
      do_rd(pat(a), "R6 R3 sweep readback");
    end
    check(bus_oe === 1'b0 && bus_out === 8'h00, "R7 idle after read", {bus_oe, bus_out}, 0);

    // R8: several strobes on one latched address
    set_addr(12'h123);
    do_wr(8'hA5);
    do_rd(8'hA5, "R8 reuse first");
    do_wr(8'h5A);
    do_rd(8'h5A, "R8 reuse second");
    do_rd(8'h5A, "R8 reuse third");
    set_addr(12'h124);
    do_rd(pat(12'h124), "R8 new latch");

    // R4 R7: one select bit high blocks the read
    for (int i = 0; i < 8; i++) begin
      sel_n = 8'(1 << i);
      set_addr(12'h010);
      rd_n = 1'b0; tick(3);
      check(bus_oe === 1'b0 && bus_out === 8'h00, "R4 R7 select off",
            {bus_oe, bus_out}, 0);
      rd_n = 1'b1; tick(3);
    end
    sel_n = '0;
    set_addr(12'h010);
    do_rd(pat(12'h010), "R4 select on");

    // R10: write with select inactive
    sel_n = 8'h80;
    set_addr(12'h020);
    do_wr(8'hEE);
    sel_n = 8'h01;
    do_wr(8'hDD);
    sel_n = '0;
    do_rd(pat(12'h020), "R10 ignored write");

    // R9: overlap, write released first
    set_addr(12'h030);
    bus_in = 8'h99;
    wr_n = 1'b0; rd_n = 1'b0; tick(4);
    check(bus_oe === 1'b0, "R9 no drive in overlap", bus_oe, 0);
    wr_n = 1'b1; tick(4);
    rd_n = 1'b1; tick(4);
    do_rd(pat(12'h030), "R9 write first release");
    // R9: overlap, both released together
    set_addr(12'h031);
    bus_in = 8'h66;
    wr_n = 1'b0; rd_n = 1'b0; tick(4);
    check(bus_oe === 1'b0, "R9 no drive in overlap 2", bus_oe, 0);
    wr_n = 1'b1; rd_n = 1'b1; tick(4);
    do_rd(pat(12'h031), "R9 joint release");
    // R9: read pulse inside a write strobe
    set_addr(12'h032);
    bus_in = 8'h77;
    wr_n = 1'b0; tick(3);
    rd_n = 1'b0; tick(3);
    rd_n = 1'b1; tick(3);
    wr_n = 1'b1; tick(4);
    do_rd(pat(12'h032), "R9 read inside write");

    // R7: release timing
    set_addr(12'h040);
    rd_n = 1'b0; tick(3);
    rd_n = 1'b1; tick(3);
    check(bus_oe === 1'b0 && bus_out === 8'h00, "R7 release", {bus_oe, bus_out}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule